// File: doc/BRIEF.md
# IEEE-488 Transceiver Direction Control

This block drives the control pins of the external bus transceivers that sit between an IEEE-488 interface controller and the cable. It takes the controller's role flags: talker, listener, active controller, controller-in-charge and parallel-poll response. From them it decides which way each group of bus lines points. There are three groups: the data, handshake and EOI lines; the ATN and SRQ lines; and the IFC and REN lines. It also picks three-state or open-collector drive for the output stage.

The IFC/REN direction follows a system-controller flag kept inside the block. A decoded "become system controller" strobe (Set IFC) sets the flag. A decoded "give up system control" strobe (Release System Control) clears it. All outputs are registered, so the transceivers see clean, glitch-free levels one clock after the role flags change.

Top module: `xcvr_dir_ctrl`

## Requirements
- R1: `dir_data` is 1 (drive) one clock after a cycle in which `is_talker` or `is_active_ctl` is 1.
- R2: `dir_data` is 0 (receive) one clock after a cycle in which neither `is_talker` nor `is_active_ctl` is 1, whether `is_listener` is set or not.
- R3: `dir_mgmt` is 1 one clock after a cycle with `is_cic` = 1, and 0 one clock after a cycle with `is_cic` = 0.
- R4: When `ppoll_resp` is 0, `drv_tristate` is 1 one clock after a cycle in which the data group drives, and 0 when it receives.
- R5: `drv_tristate` is 0 (open-collector) one clock after any cycle with `ppoll_resp` = 1, even while the data group drives.
- R6: `sys_ctl` is 1 one clock after a cycle with `cmd_set_ifc` = 1 and `cmd_rel_sc` = 0.
- R7: `sys_ctl` is 0 one clock after a cycle with `cmd_rel_sc` = 1, including when `cmd_set_ifc` is also 1.
- R8: With neither strobe asserted, `sys_ctl` holds its value, whatever the role flags do.
- R9: While `rst_n` is 0, all four outputs are 0 (everything receives, open-collector), and strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| is_talker | input | 1 | Controller is addressed as talker |
| is_listener | input | 1 | Controller is addressed as listener |
| is_active_ctl | input | 1 | Controller is the active controller |
| is_cic | input | 1 | Controller is controller-in-charge |
| ppoll_resp | input | 1 | Parallel-poll response in progress |
| cmd_set_ifc | input | 1 | Decoded Set IFC command strobe |
| cmd_rel_sc | input | 1 | Decoded Release System Control command strobe |
| dir_data | output | 1 | Data/handshake/EOI direction, 1 = drive |
| dir_mgmt | output | 1 | ATN/SRQ direction, 1 = drive |
| drv_tristate | output | 1 | Driver mode, 1 = three-state, 0 = open-collector |
| sys_ctl | output | 1 | System-controller flag; IFC/REN direction, 1 = drive |

## Verification
Every output is due exactly one rising edge after the inputs that cause it. This holds for the direction lines, the driver mode and the system-controller flag alike. The bench therefore sets inputs on a falling edge and samples on the next falling edge, with one rising edge in between. The exception is reset: it clears the outputs at once, so those checks sample a moment after `rst_n` falls. A further check, made after a rising edge with a strobe held under reset, shows that the strobe was ignored.

// File: rtl/xcvr_dir_ctrl.sv
module xcvr_dir_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic is_talker,
  input  logic is_listener,
  input  logic is_active_ctl,
  input  logic is_cic,
  input  logic ppoll_resp,
  input  logic cmd_set_ifc,
  input  logic cmd_rel_sc,
  output logic dir_data,
  output logic dir_mgmt,
  output logic drv_tristate,
  output logic sys_ctl
);

  logic data_drv_n;
  logic sc_n;

  // listener alone, or no role at all, leaves the data group receiving
  assign data_drv_n = is_talker | is_active_ctl;

  always_comb begin
    sc_n = sys_ctl;
    if (cmd_set_ifc) sc_n = 1'b1;
    if (cmd_rel_sc)  sc_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_data     <= 1'b0;
      dir_mgmt     <= 1'b0;
      drv_tristate <= 1'b0;
      sys_ctl      <= 1'b0;
    end else begin
      dir_data     <= data_drv_n;
      dir_mgmt     <= is_cic;
      drv_tristate <= data_drv_n & ~ppoll_resp;
      sys_ctl      <= sc_n;
    end
  end

  AST_DATA_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (is_talker || is_active_ctl) |=> dir_data); // R1
  AST_DATA_RECV: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_talker && !is_active_ctl) |=> !dir_data); // R2
  AST_MGMT_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (dir_mgmt == $past(is_cic))); // R3
  AST_TRISTATE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !ppoll_resp |=> (drv_tristate == dir_data)); // R4
  AST_PPOLL_OC: assert property (@(posedge clk) disable iff (!rst_n)
    ppoll_resp |=> !drv_tristate); // R5
  AST_SC_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_set_ifc && !cmd_rel_sc) |=> sys_ctl); // R6
  AST_SC_REL: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rel_sc |=> !sys_ctl); // R7
  AST_SC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_set_ifc && !cmd_rel_sc) |=> $stable(sys_ctl)); // R8

endmodule

// File: tb/xcvr_dir_ctrl_tb.sv
module xcvr_dir_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic is_talker = 0, is_listener = 0, is_active_ctl = 0, is_cic = 0;
  logic ppoll_resp = 0, cmd_set_ifc = 0, cmd_rel_sc = 0;
  logic dir_data, dir_mgmt, drv_tristate, sys_ctl;
  int n_checks = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  xcvr_dir_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .is_talker(is_talker), .is_listener(is_listener),
    .is_active_ctl(is_active_ctl), .is_cic(is_cic),
    .ppoll_resp(ppoll_resp), .cmd_set_ifc(cmd_set_ifc), .cmd_rel_sc(cmd_rel_sc),
    .dir_data(dir_data), .dir_mgmt(dir_mgmt),
    .drv_tristate(drv_tristate), .sys_ctl(sys_ctl)
  );

  // {talker, listener, active, cic, ppoll, set, rel} -> {dir_data, dir_mgmt, tristate, sys_ctl}
  localparam int NV = 14;
  localparam logic [10:0] VEC [NV] = '{
    {7'b0000000, 4'b0000},  // idle: all receive               R2
    {7'b1000000, 4'b1010},  // talker drives, three-state      R1 R4
    {7'b0100000, 4'b0000},  // listener receives               R2
    {7'b0011000, 4'b1110},  // active + cic                    R1 R3
    {7'b0001000, 4'b0100},  // cic only                        R3 R2
    {7'b1000100, 4'b1000},  // talker in ppoll: open-collector R5
    {7'b0000010, 4'b0001},  // set                             R6
    {7'b0000000, 4'b0001},  // hold                            R8
    {7'b0101000, 4'b0101},  // roles change, flag holds        R8
    {7'b0000011, 4'b0000},  // set+rel: release wins           R7
    {7'b0000010, 4'b0001},  // set again                       R6
    {7'b0000001, 4'b0000},  // release                         R7
    {7'b0011100, 4'b1100},  // active+cic in ppoll             R5
    {7'b1000010, 4'b1011}   // talker + set                    R1 R6
  };

  task automatic chk(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic chk_all(input logic [3:0] e);
    chk("R1 R2 dir_data", dir_data, e[3]);
    chk("R3 dir_mgmt", dir_mgmt, e[2]);
    chk("R4 R5 drv_tristate", drv_tristate, e[1]);
    chk("R6 R7 R8 sys_ctl", sys_ctl, e[0]);
  endtask

  task automatic drive(input logic [6:0] v);
    {is_talker, is_listener, is_active_ctl, is_cic, ppoll_resp, cmd_set_ifc, cmd_rel_sc} = v;
  endtask

  initial begin
    #200000;
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_all(4'b0000);  // R9 reset state
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][10:4]);
      @(negedge clk);
      chk_all(VEC[i][3:0]);
    end
    // R9: asynchronous reset clears everything at once
    drive(7'b1011000);
    @(negedge clk);
    chk_all(4'b1111 & 4'b1111 ^ 4'b0000 & 4'b1111 ? 4'b1111 : 4'b1111);
    #1 rst_n = 1'b0;
    #1 chk_all(4'b0000);
    // R9: set strobe under reset has no effect
    drive(7'b1011010);
    @(negedge clk);
    chk_all(4'b0000);
    drive(7'b0000000);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all(4'b0000);  // R8 flag still clear after reset released
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule